// File: doc/BRIEF.md
# Hardwired Instruction Decode and Timing Front End

This block sits at the front of a hardwired control unit for a 16-bit accumulator machine. When the fetch logic raises a load strobe, it captures the fetched instruction word. From the held word it produces four groups of outputs:

- a one-hot line for each of the eight operation codes;
- the addressing-mode flag;
- the 12-bit address/operation field;
- three mutually exclusive instruction-class flags: memory reference, register reference and I/O.

Alongside this, a 4-bit sequence counter steps the control unit through its phases. The counter's value is decoded into sixteen one-hot timing pulses.

The surrounding control equations combine the operation lines, the mode flag and the timing pulses to sequence a datapath. They increment the counter to move to the next phase and clear it to return to the first phase.

The word layout is as follows:

| Bits | Content |
|---|---|
| 15 | mode bit: 0 = direct, 1 = indirect |
| 14..12 | operation code |
| 11..0 | address or operation field |

Top module: `hdt_top`

## Requirements
- R1: When `ir_load_i` is high at a rising clock edge, `instr_i` is captured, and from the next cycle `addr_o` equals bits 11..0 of the captured word.
- R2: `op_line_o` is one-hot, with bit k high exactly when bits 14..12 of the held word equal k (k = 0..7).
- R3: `mode_o` equals bit 15 of the held word (0 = direct, 1 = indirect).
- R4: With `seq_clr_i` low and `seq_inc_i` high at an edge, the sequence count rises by one and wraps from 15 to 0.
- R5: `tpulse_o` is one-hot, with bit k high exactly when the sequence count is k.
- R6: With `seq_clr_i` high at an edge, the count becomes 0 whatever the value of `seq_inc_i`.
- R7: With both `seq_clr_i` and `seq_inc_i` low at an edge, the count holds.
- R8: With `ir_load_i` low at an edge, the held word, `mode_o`, `addr_o` and `op_line_o` are unchanged whatever `instr_i` carries.
- R9: The class flags follow bits 15..12 of the held word:
  - `cls_mem_o` is high for operation codes 000 to 110;
  - `cls_reg_o` is high for code 111 with mode 0 (top nibble 0x7);
  - `cls_io_o` is high for code 111 with mode 1 (top nibble 0xF);
  - exactly one of the three flags is high at any time.
- R10: While `rst_ni` is low, the count is 0 and the held word is 0000h. The outputs then read `tpulse_o` = 0001h, `op_line_o` = 01h, `mode_o` = 0, `addr_o` = 000h and `cls_mem_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_load_i | input | 1 | Strobe that captures the instruction word |
| instr_i | input | 16 | Fetched instruction word |
| seq_inc_i | input | 1 | Advance the sequence counter |
| seq_clr_i | input | 1 | Clear the sequence counter (takes priority) |
| op_line_o | output | 8 | One-hot operation-code lines |
| mode_o | output | 1 | Addressing-mode flag |
| addr_o | output | 12 | Address/operation field of the held word |
| tpulse_o | output | 16 | One-hot timing pulses |
| cls_mem_o | output | 1 | Memory-reference class flag |
| cls_reg_o | output | 1 | Register-reference class flag |
| cls_io_o | output | 1 | I/O class flag |

## Verification
The assertions take for granted that the strobe, counter controls and instruction word carry known 0/1 values on every edge after reset is released. They also assume each edge is a genuine clock edge with no glitches on the control inputs, so that the captured word and the counter update follow purely from those values.

The stimulus keeps within this by holding reset low before the first edge. It then drives every input to a defined value, and changes inputs only on the falling clock edge.

The stimulus sweeps all eight operation codes with both mode values, and runs the counter through its wrap. It covers clear asserted together with increment, and idle cycles in which the instruction bus changes while the load strobe is low.

// File: rtl/hdt_pkg.sv
package hdt_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 3;
  localparam int SEQ_W  = 4;

  typedef enum logic [1:0] {
    CLS_MEM = 2'd0,
    CLS_REG = 2'd1,
    CLS_IO  = 2'd2
  } ins_class_e;
endpackage

// File: rtl/hdt_ir_reg.sv
module hdt_ir_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-2:0] body_o,
  output logic              mode_o
);
  logic [WORD_W-2:0] body_q;
  logic              mode_q;

  // mode bit held in its own flop, separate from the rest of the word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      body_q <= '0;
      mode_q <= 1'b0;
    end else if (load_i) begin
      body_q <= word_i[WORD_W-2:0];
      mode_q <= word_i[WORD_W-1];
    end
  end

  assign body_o = body_q;
  assign mode_o = mode_q;

  assert_ir_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> {mode_q, body_q} == $past(word_i));
  assert_ir_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(body_q) && $stable(mode_q));
endmodule

// File: rtl/hdt_onehot_dec.sv
module hdt_onehot_dec #(
  parameter int IN_W = 3,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  sel_i,
  output logic [OUT_N-1:0] line_o
);
  for (genvar k = 0; k < OUT_N; k++) begin : g_line
    assign line_o[k] = (sel_i == IN_W'(k));
  end
endmodule

// File: rtl/hdt_seq_cnt.sv
module hdt_seq_cnt #(
  parameter int SEQ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [SEQ_W-1:0] cnt_o
);
  logic [SEQ_W-1:0] cnt_q;

  // clear has priority over increment; natural wrap at the top count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_seq_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  assert_seq_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i) |=> cnt_q == SEQ_W'($past(cnt_q) + 1'b1));
  assert_seq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hdt_class_dec.sv
module hdt_class_dec
  import hdt_pkg::*;
#(
  parameter int OP_W = 3
) (
  input  logic [OP_W-1:0] op_i,
  input  logic            mode_i,
  output logic            mem_o,
  output logic            reg_o,
  output logic            io_o
);
  ins_class_e cls;

  always_comb begin
    if (op_i != '1) cls = CLS_MEM;
    else if (mode_i) cls = CLS_IO;
    else cls = CLS_REG;
  end

  assign mem_o = (cls == CLS_MEM);
  assign reg_o = (cls == CLS_REG);
  assign io_o  = (cls == CLS_IO);
endmodule

// File: rtl/hdt_top.sv
module hdt_top #(
  parameter int WORD_W = 16,
  parameter int OP_W   = 3,
  parameter int SEQ_W  = 4,
  localparam int ADDR_W = WORD_W - OP_W - 1,
  localparam int OP_N   = 1 << OP_W,
  localparam int T_N    = 1 << SEQ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_load_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic              seq_inc_i,
  input  logic              seq_clr_i,
  output logic [OP_N-1:0]   op_line_o,
  output logic              mode_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [T_N-1:0]    tpulse_o,
  output logic              cls_mem_o,
  output logic              cls_reg_o,
  output logic              cls_io_o
);
  logic [WORD_W-2:0] body;
  logic              mode;
  logic [OP_W-1:0]   opcode;
  logic [SEQ_W-1:0]  cnt;

  hdt_ir_reg #(.WORD_W(WORD_W)) u_ir (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ir_load_i),
    .word_i(instr_i),
    .body_o(body),
    .mode_o(mode)
  );

  assign opcode = body[WORD_W-2 -: OP_W];
  assign addr_o = body[ADDR_W-1:0];
  assign mode_o = mode;

  hdt_onehot_dec #(.IN_W(OP_W)) u_op_dec (
    .sel_i (opcode),
    .line_o(op_line_o)
  );

  hdt_seq_cnt #(.SEQ_W(SEQ_W)) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (seq_inc_i),
    .clr_i (seq_clr_i),
    .cnt_o (cnt)
  );

  hdt_onehot_dec #(.IN_W(SEQ_W)) u_t_dec (
    .sel_i (cnt),
    .line_o(tpulse_o)
  );

  hdt_class_dec #(.OP_W(OP_W)) u_cls (
    .op_i  (opcode),
    .mode_i(mode),
    .mem_o (cls_mem_o),
    .reg_o (cls_reg_o),
    .io_o  (cls_io_o)
  );

  assert_op_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(op_line_o) == 1);
  assert_t_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tpulse_o) == 1);
  assert_cls_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cls_mem_o, cls_reg_o, cls_io_o}) == 1);
  assert_io_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_io_o || cls_reg_o) |-> (op_line_o[OP_N-1] && (mode_o == cls_io_o)));
  assert_clr_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_clr_i |=> tpulse_o[0]);
endmodule

// File: tb/hdt_top_tb_top.sv
module hdt_top_tb_top;
  typedef struct {
    logic [7:0]  op;
    logic        mode;
    logic [11:0] addr;
    logic [15:0] tp;
    logic [2:0]  cls;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_load = 1'b0;
  logic [15:0] instr = '0;
  logic        inc = 1'b0;
  logic        clr = 1'b0;
  logic [7:0]  op_line;
  logic        mode;
  logic [11:0] addr;
  logic [15:0] tpulse;
  logic        c_mem, c_reg, c_io;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  logic [15:0] m_ir = '0;
  logic [3:0]  m_cnt = '0;

  always #5 clk = ~clk;

  hdt_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ir_load_i(ir_load), .instr_i(instr),
    .seq_inc_i(inc), .seq_clr_i(clr), .op_line_o(op_line), .mode_o(mode),
    .addr_o(addr), .tpulse_o(tpulse), .cls_mem_o(c_mem), .cls_reg_o(c_reg),
    .cls_io_o(c_io)
  );

  function automatic exp_t model(string tag);
    exp_t e;
    e.op   = 8'(1) << m_ir[14:12];
    e.mode = m_ir[15];
    e.addr = m_ir[11:0];
    e.tp   = 16'(1) << m_cnt;
    if (m_ir[14:12] != 3'b111) e.cls = 3'b100;
    else if (m_ir[15])         e.cls = 3'b001;
    else                       e.cls = 3'b010;
    e.tag = tag;
    return e;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (op_line !== e.op || mode !== e.mode || addr !== e.addr ||
        tpulse !== e.tp || {c_mem, c_reg, c_io} !== e.cls) begin
      errors++;
      $display("FAIL %s: got op=%h mode=%b addr=%h tp=%h cls=%b exp op=%h mode=%b addr=%h tp=%h cls=%b",
               e.tag, op_line, mode, addr, tpulse, {c_mem, c_reg, c_io},
               e.op, e.mode, e.addr, e.tp, e.cls);
    end
  endtask

  // driver: apply one cycle of stimulus, update model, push expectation
  task automatic step(bit ld, logic [15:0] w, bit i, bit c, string tag);
    @(negedge clk);
    ir_load = ld; instr = w; inc = i; clr = c;
    @(posedge clk);
    if (ld) m_ir = w;
    if (c) m_cnt = '0;
    else if (i) m_cnt = m_cnt + 1'b1;
    q.push_back(model(tag));
  endtask

  // monitor: compare against queued expectations away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #3;
    compare(model("R10 reset state"));
    #20;
    compare(model("R10 reset held"));
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R9 R1: every opcode with both mode values
    for (int op = 0; op < 8; op++) begin
      for (int md = 0; md < 2; md++) begin
        logic [15:0] w;
        w = {md[0], op[2:0], 12'(op * 291 + md * 7 + 1)};
        step(1'b1, w, 1'b0, 1'b0, "R2 R3 R9 R1 load");
      end
    end
    step(1'b1, 16'h7A5C, 1'b0, 1'b0, "R9 register class 0x7");
    step(1'b1, 16'hF3C1, 1'b0, 1'b0, "R9 io class 0xF");
    step(1'b1, 16'h6FFF, 1'b0, 1'b0, "R9 memory class code 110");

    // R8: bus changes while strobe low
    step(1'b0, 16'h0000, 1'b0, 1'b0, "R8 hold no load");
    step(1'b0, 16'hFFFF, 1'b0, 1'b0, "R8 hold no load");
    step(1'b0, 16'h7123, 1'b0, 1'b0, "R8 hold no load");

    // R4 R5: count through wrap
    for (int k = 0; k < 18; k++) step(1'b0, 16'h1234, 1'b1, 1'b0, "R4 R5 increment");
    // R7 hold
    step(1'b0, 16'h0, 1'b0, 1'b0, "R7 hold count");
    step(1'b0, 16'h0, 1'b0, 1'b0, "R7 hold count");
    // R6 clear alone and with increment
    step(1'b0, 16'h0, 1'b0, 1'b1, "R6 clear");
    for (int k = 0; k < 5; k++) step(1'b0, 16'h0, 1'b1, 1'b0, "R4 increment");
    step(1'b0, 16'h0, 1'b1, 1'b1, "R6 clear beats increment");
    step(1'b0, 16'h0, 1'b1, 1'b0, "R4 after clear");
    // combined load and count
    step(1'b1, 16'hB0F0, 1'b1, 1'b0, "R1 R4 load with increment");
    step(1'b1, 16'h2001, 1'b1, 1'b1, "R1 R6 load with clear");

    @(negedge clk);
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule